// File: doc/BRIEF.md
# Multi-Mode Waveform Timer

A 16-bit timer-counter that moves one step for each count-enable pulse from an external prescaler. A 4-bit mode field picks five things: the counting scheme (single-slope free run, clear-on-match, fast PWM, or one of two dual-slope schemes), the source of the TOP value (a fixed 8/9/10/16-bit limit, the active compare value of channel A, or the capture register), the event that raises the overflow flag, when buffered compare values become active, and how each channel's 2-bit output code drives its waveform pin. Three compare channels drive three waveform pins. Each pin comes with an output-enable that is low whenever the pin is disconnected. A capture input latches the counter value on a selected edge. An optional filter rejects short glitches on that input.

Software reaches the block through a plain single-cycle register write port (`wr_en`, `wr_addr`, `wr_data`). The port has no handshake and is never back-pressured: every write with `wr_en` high takes effect at that clock edge. Address 0 holds control: mode [3:0], output codes A [5:4], B [7:6], C [9:8], capture edge select [10] and filter enable [11]. The other addresses are: 1 loads the counter; 2, 3 and 4 are the compare buffers A, B and C; 5 is the capture register; 6 clears flags (write 1 to clear); 7 holds the interrupt enable mask [4:0] and carries the force strobes for A, B and C in [10:8]. Flag bits are: 0 overflow, 1–3 compare A–C, 4 capture. The counter value, the capture register and the flags are visible as plain status outputs.

A compare match is a count-enable pulse that arrives while the counter equals a channel's active compare value. The output action and the compare flag take effect at that same edge.

Top module: `wavetimer`

## Requirements
- R1: After reset the counter, the capture register, all flags, `irq_o`, `wave_o` and `wave_oe` are zero.
- R2: In mode 0 the counter rises by one per enable pulse, holds without one, and wraps from 0xFFFF to 0, setting flag bit 0 at the wrap. In mode 13 the counter holds even with enable pulses.
- R3: In mode 4 the counter runs 0..compare A and then returns to 0. A match sets that channel's flag, and code 01 toggles the pin on each match. In this mode a compare write becomes active at once, and flag bit 0 stays clear while the count never reaches 0xFFFF.
- R4: In fast PWM (mode 5, TOP 0x00FF) code 10 sets the pin at TOP and clears it on a match, and code 11 does the inverse. Flag bit 0 sets at TOP. A compare write becomes active only at the next TOP.
- R5: In mode 1 (dual slope, TOP 0x00FF) the counter turns at TOP and at BOTTOM, each held for one count. Flag bit 0 sets at BOTTOM, not at TOP. Code 10 clears on an up-count match and sets on a down-count match.
- R6: In mode 8 (dual slope, TOP from the capture register) compare writes become active at BOTTOM, not at TOP. Code 11 sets on an up-count match and clears on a down-count match. Flag bit 0 sets at BOTTOM.
- R7: Code 01 connects the pin only in non-PWM modes, or on channel A in modes 9, 11 and 15. In mode 15 it toggles A on each match and TOP comes from compare A.
- R8: With edge select 1 a rising capture-input edge copies the counter into the capture register and sets flag bit 4; with 0 the falling edge does this. The other edge has no effect. Capture is ignored in modes whose TOP is the capture register (8, 10, 12, 14).
- R9: With the filter enabled, a capture-input level must be seen on 4 consecutive clocks before it counts, so a 3-clock pulse is ignored. With the filter off the same pulse is captured.
- R10: Writing 1 to a flag bit at address 6 clears only that flag. `irq_o` is high exactly when a flag and its mask bit are both set.
- R11: A force strobe applies the channel's output action at once in modes 0, 4, 12 and 13 without setting its flag. In PWM modes it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-enable pulse from the prescaler |
| capt_in | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| cnt_o | output | 16 | Current counter value |
| capt_o | output | 16 | Capture register |
| flags_o | output | 5 | Flags: overflow, compare A–C, capture |
| irq_o | output | 1 | Masked OR of the flags |
| wave_o | output | 3 | Waveform pins A, B, C |
| wave_oe | output | 3 | High while the pin is connected |

## Verification
Each counting scheme is driven with compare values that sit well inside the count range. Single-slope runs show where the counter wraps and whether the overflow flag comes at MAX or at TOP. Dual-slope runs show that each end value is held for one count and that the overflow flag comes at BOTTOM. A compare value rewritten in the middle of a period separates immediate activation from activation at TOP or at BOTTOM, because the pin changes only where the old value would match. On the capture input, pulses of both polarities and of 3 and 8 clocks separate edge selection, filtering and the TOP-from-capture lockout.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

  typedef enum logic [2:0] {K_NORM, K_CTC, K_FAST, K_PC, K_PFC, K_HALT} kind_e;
  typedef enum logic [1:0] {T_FIX, T_CMPA, T_CAPT} tsel_e;

  typedef struct packed {
    kind_e      kind;
    tsel_e      tsel;
    logic [1:0] res;    // fixed TOP: 0 full width, 1 8-bit, 2 9-bit, 3 10-bit
    logic       tog_a;  // code 01 toggles channel A in this PWM mode
  } mode_t;

  localparam int NCH   = 3;
  localparam int NFLAG = 5;

  function automatic mode_t decode(input logic [3:0] m);
    mode_t d;
    d.kind  = K_NORM;
    d.tsel  = T_FIX;
    d.res   = 2'd0;
    d.tog_a = 1'b0;
    case (m)
      4'd1, 4'd2, 4'd3: begin d.kind = K_PC;   d.res = m[1:0]; end
      4'd4:             begin d.kind = K_CTC;  d.tsel = T_CMPA; end
      4'd5, 4'd6, 4'd7: begin d.kind = K_FAST; d.res = m[1:0]; end
      4'd8:             begin d.kind = K_PFC;  d.tsel = T_CAPT; end
      4'd9:             begin d.kind = K_PFC;  d.tsel = T_CMPA; d.tog_a = 1'b1; end
      4'd10:            begin d.kind = K_PC;   d.tsel = T_CAPT; end
      4'd11:            begin d.kind = K_PC;   d.tsel = T_CMPA; d.tog_a = 1'b1; end
      4'd12:            begin d.kind = K_CTC;  d.tsel = T_CAPT; end
      4'd13:            begin d.kind = K_HALT; end
      4'd14:            begin d.kind = K_FAST; d.tsel = T_CAPT; end
      4'd15:            begin d.kind = K_FAST; d.tsel = T_CMPA; d.tog_a = 1'b1; end
      default: ;
    endcase
    return d;
  endfunction

  function automatic logic is_pwm(input kind_e k);
    return (k == K_FAST) || (k == K_PC) || (k == K_PFC);
  endfunction

endpackage

// File: rtl/wtm_count.sv
module wtm_count import wtm_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  kind_e        kind,
  input  logic [W-1:0] top,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         ev_top,
  output logic         ev_bot,
  output logic         ev_max
);
  localparam logic [W-1:0] MAXV = '1;

  logic dual;
  assign dual   = (kind == K_PC) || (kind == K_PFC);
  assign ev_max = tick && ((kind == K_NORM) || (kind == K_CTC)) && (cnt == MAXV);
  assign ev_top = tick && (cnt == top) && ((kind == K_FAST) || (dual && up));
  assign ev_bot = tick && dual && !up && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (tick) begin
      case (kind)
        K_NORM, K_CTC, K_FAST: begin
          up  <= 1'b1;
          cnt <= (cnt == top) ? '0 : cnt + 1'b1;
        end
        K_PC, K_PFC: begin
          if (top == '0) begin
            cnt <= '0;
          end else if (up) begin
            if (cnt >= top) begin
              up  <= 1'b0;
              cnt <= cnt - 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wtm_capt.sv
module wtm_capt #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic filt_en,
  output logic evt
);
  logic             s1, s2, lvl, lvl_d;
  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      lvl  <= 1'b0;
      hist <= '0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      hist <= {hist[DEPTH-2:0], s2};
      lvl  <= lvl_d;
    end
  end

  always_comb begin
    lvl_d = lvl;
    if (!filt_en)    lvl_d = s2;
    else if (&hist)  lvl_d = 1'b1;
    else if (~|hist) lvl_d = 1'b0;
  end

  assign evt = (lvl_d != lvl) && (lvl_d == rise_sel);
endmodule

// File: rtl/wtm_wave.sv
module wtm_wave import wtm_pkg::*; #(
  parameter bit IS_A = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  kind_e      kind,
  input  logic       tog_a,
  input  logic [1:0] code,
  input  logic       match,
  input  logic       up,
  input  logic       at_top,
  input  logic       force_i,
  output logic       pin,
  output logic       oe
);
  logic pwm, conn, q, q_d;

  assign pwm  = is_pwm(kind);
  assign conn = (code != 2'b00) && !(code == 2'b01 && pwm && !(IS_A && tog_a));

  always_comb begin
    q_d = q;
    if (conn) begin
      if (!pwm) begin
        if (match || force_i) begin
          case (code)
            2'b01:   q_d = ~q;
            2'b10:   q_d = 1'b0;
            default: q_d = 1'b1;
          endcase
        end
      end else if (code == 2'b01) begin
        if (match) q_d = ~q;
      end else if (kind == K_FAST) begin
        if (at_top)     q_d = ~code[0];
        else if (match) q_d = code[0];
      end else if (match) begin
        q_d = up ? code[0] : ~code[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  assign pin = q & conn;
  assign oe  = conn;
endmodule

// File: rtl/wavetimer.sv
module wavetimer import wtm_pkg::*; #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             capt_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     cnt_o,
  output logic [W-1:0]     capt_o,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o,
  output logic [NCH-1:0]   wave_o,
  output logic [NCH-1:0]   wave_oe
);
  localparam int A_CTRL  = 0;
  localparam int A_CNT   = 1;
  localparam int A_CMP0  = 2;
  localparam int A_CAPT  = A_CMP0 + NCH;
  localparam int A_FCLR  = A_CAPT + 1;
  localparam int A_MASK  = A_FCLR + 1;
  localparam int CODE_LO = 4;
  localparam int RISE_B  = CODE_LO + 2 * NCH;
  localparam int FILT_B  = RISE_B + 1;
  localparam int FRC_LO  = 8;

  logic [3:0]           mode_q;
  logic [NCH-1:0][1:0]  code_q;
  logic                 rise_q, filt_q;
  logic [W-1:0]         capt_q;
  logic [NFLAG-1:0]     flag_q, mask_q, flag_set, flag_clr;
  logic [NCH-1:0][W-1:0] act_all;
  logic [NCH-1:0]       hit;
  mode_t                md;
  logic [W-1:0]         top, cnt;
  logic                 up, ev_top, ev_bot, ev_max, imm, upd, ovf_evt, cap_evt, cap_ok;
  logic                 wr_ctrl, wr_cnt, wr_capt, wr_fclr, wr_mask;

  assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
  assign wr_cnt  = wr_en && (wr_addr == AW'(A_CNT));
  assign wr_capt = wr_en && (wr_addr == AW'(A_CAPT));
  assign wr_fclr = wr_en && (wr_addr == AW'(A_FCLR));
  assign wr_mask = wr_en && (wr_addr == AW'(A_MASK));

  assign md = decode(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      code_q <= '0;
      rise_q <= 1'b0;
      filt_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wr_data[3:0];
        code_q <= wr_data[CODE_LO +: 2*NCH];
        rise_q <= wr_data[RISE_B];
        filt_q <= wr_data[FILT_B];
      end
      if (wr_mask) mask_q <= wr_data[NFLAG-1:0];
    end
  end

  always_comb begin
    case (md.tsel)
      T_CMPA: top = act_all[0];
      T_CAPT: top = capt_q;
      default: begin
        case (md.res)
          2'd1:    top = W'(8'hFF);
          2'd2:    top = W'(9'h1FF);
          2'd3:    top = W'(10'h3FF);
          default: top = '1;
        endcase
      end
    endcase
  end

  wtm_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en), .kind(md.kind), .top(top),
    .ld(wr_cnt), .ld_val(wr_data), .cnt(cnt), .up(up),
    .ev_top(ev_top), .ev_bot(ev_bot), .ev_max(ev_max)
  );

  assign imm = (md.kind == K_NORM) || (md.kind == K_CTC);
  assign upd = (((md.kind == K_FAST) || (md.kind == K_PC)) && ev_top) ||
               ((md.kind == K_PFC) && ev_bot);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [W-1:0] buf_q, act_q, buf_d;
    logic         wr_i, frc_i;

    assign wr_i  = wr_en && (wr_addr == AW'(A_CMP0 + i));
    assign buf_d = wr_i ? wr_data : buf_q;
    assign frc_i = wr_mask && wr_data[FRC_LO + i];
    assign hit[i] = cnt_en && (md.kind != K_HALT) && (cnt == act_q);
    assign act_all[i] = act_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_q <= '0;
        act_q <= '0;
      end else begin
        buf_q <= buf_d;
        if (imm)      act_q <= buf_d;
        else if (upd) act_q <= buf_q;
      end
    end

    wtm_wave #(.IS_A(i == 0)) u_wave (
      .clk(clk), .rst_n(rst_n), .kind(md.kind), .tog_a(md.tog_a),
      .code(code_q[i]), .match(hit[i]), .up(up), .at_top(ev_top),
      .force_i(frc_i && !is_pwm(md.kind)), .pin(wave_o[i]), .oe(wave_oe[i])
    );
  end

  wtm_capt #(.DEPTH(4)) u_capt (
    .clk(clk), .rst_n(rst_n), .pin(capt_in), .rise_sel(rise_q),
    .filt_en(filt_q), .evt(cap_evt)
  );

  assign cap_ok = cap_evt && (md.tsel != T_CAPT);

  always_ff @(posedge clk) begin
    if (!rst_n)       capt_q <= '0;
    else if (wr_capt) capt_q <= wr_data;
    else if (cap_ok)  capt_q <= cnt;
  end

  assign ovf_evt  = ev_max || ((md.kind == K_FAST) && ev_top) || ev_bot;
  assign flag_set = {cap_ok, hit, ovf_evt};
  assign flag_clr = wr_fclr ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign cnt_o   = cnt;
  assign capt_o  = capt_q;
  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & mask_q);
endmodule

// File: rtl/wavetimer_chk.sv
module wavetimer_chk #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic [3:0]    mode,
  input logic [W-1:0]  cnt,
  input logic [4:0]    flags,
  input logic          irq
);
  logic cfg_wr;
  assign cfg_wr = wr_en && (wr_addr == AW'(0) || wr_addr == AW'(1));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0 && cnt_en && !cfg_wr) |=> (cnt == W'($past(cnt) + 1'b1)));

  p_wrap_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0 && cnt_en && cnt == '1 && !cfg_wr) |=> flags[0]);

  p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd13 && !(wr_en && wr_addr == AW'(1))) |=> $stable(cnt));

  p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 5'd0) |-> !irq);

  p_force_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(7) && wr_data[8] && !cnt_en && !flags[1]) |=> !flags[1]);
endmodule

bind wavetimer wavetimer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mode(mode_q), .cnt(cnt_o), .flags(flags_o), .irq(irq_o)
);

// File: tb/wavetimer_bench.sv
module wavetimer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        capt_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_o, capt_o;
  logic [4:0]  flags_o;
  logic        irq_o;
  logic [2:0]  wave_o, wave_oe;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  wavetimer u_wavetimer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .capt_in(capt_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .capt_o(capt_o), .flags_o(flags_o), .irq_o(irq_o),
    .wave_o(wave_o), .wave_oe(wave_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input int m, input int ca, input int cb,
                                     input int cc, input bit rise, input bit filt);
    return {4'b0, filt, rise, 2'(cc), 2'(cb), 2'(ca), 4'(m)};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; capt_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    idle(1);
    chk("R1 cnt", 32'(cnt_o), 0);
    chk("R1 capt", 32'(capt_o), 0);
    chk("R1 flags", 32'(flags_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 wave", 32'(wave_o), 0);
    chk("R1 oe", 32'(wave_oe), 0);
  endtask

  task automatic t_normal();
    do_reset();
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    wr(1, 16'hFFFD);
    ticks(2);
    chk("R2 cnt before wrap", 32'(cnt_o), 32'hFFFF);
    chk("R2 no ovf before wrap", 32'(flags_o[0]), 0);
    ticks(1);
    chk("R2 wrap to zero", 32'(cnt_o), 0);
    chk("R2 ovf at wrap", 32'(flags_o[0]), 1);
    idle(5);
    chk("R2 hold without enable", 32'(cnt_o), 0);
    wr(0, ctl(13, 0, 0, 0, 0, 0));
    ticks(4);
    chk("R2 mode 13 holds", 32'(cnt_o), 0);
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    ticks(3);
    chk("R2 counts again", 32'(cnt_o), 3);
  endtask

  task automatic t_ctc();
    do_reset();
    wr(0, ctl(4, 1, 0, 0, 0, 0));
    wr(2, 16'd5);
    ticks(5);
    chk("R3 cnt at top", 32'(cnt_o), 5);
    chk("R3 pin before match", 32'(wave_o[0]), 0);
    ticks(1);
    chk("R3 clear to zero", 32'(cnt_o), 0);
    chk("R3 toggle on match", 32'(wave_o[0]), 1);
    chk("R3 compare flag", 32'(flags_o[1]), 1);
    ticks(6);
    chk("R3 toggle back", 32'(wave_o[0]), 0);
    wr(2, 16'd2);
    ticks(3);
    chk("R3 immediate compare cnt", 32'(cnt_o), 0);
    chk("R3 immediate compare pin", 32'(wave_o[0]), 1);
    chk("R3 no ovf below max", 32'(flags_o[0]), 0);
  endtask

  task automatic t_fast();
    do_reset();
    wr(0, ctl(5, 0, 2, 3, 0, 0));
    wr(3, 16'h0010);
    wr(4, 16'h0010);
    ticks(255);
    chk("R4 cnt at top", 32'(cnt_o), 32'hFF);
    chk("R4 no ovf before top", 32'(flags_o[0]), 0);
    ticks(1);
    chk("R4 wrap at top", 32'(cnt_o), 0);
    chk("R4 ovf at top", 32'(flags_o[0]), 1);
    chk("R4 code10 set at top", 32'(wave_o[1]), 1);
    chk("R4 code11 clear at top", 32'(wave_o[2]), 0);
    wr(6, 16'h001F);
    ticks(8);
    wr(3, 16'h0080);
    wr(4, 16'h0080);
    ticks(9);
    chk("R4 old compare still active cnt", 32'(cnt_o), 32'h11);
    chk("R4 code10 clear on match", 32'(wave_o[1]), 0);
    chk("R4 code11 set on match", 32'(wave_o[2]), 1);
    ticks(32'hEF);
    chk("R4 second top set", 32'(wave_o[1]), 1);
    ticks(32'h11);
    chk("R4 new compare not yet hit", 32'(wave_o[1]), 1);
    ticks(32'h70);
    chk("R4 new compare hit cnt", 32'(cnt_o), 32'h81);
    chk("R4 new compare clear", 32'(wave_o[1]), 0);
    chk("R4 new compare set inverse", 32'(wave_o[2]), 1);
  endtask

  task automatic t_pc();
    do_reset();
    wr(0, ctl(1, 2, 0, 0, 0, 0));
    wr(2, 16'h0040);
    ticks(256);
    chk("R5 turn at top", 32'(cnt_o), 32'hFE);
    chk("R5 no ovf at top", 32'(flags_o[0]), 0);
    ticks(32'hBE);
    chk("R5 down to compare", 32'(cnt_o), 32'h40);
    ticks(1);
    chk("R5 set on down match", 32'(wave_o[0]), 1);
    ticks(32'h3F);
    chk("R5 reach bottom", 32'(cnt_o), 0);
    chk("R5 no ovf before bottom", 32'(flags_o[0]), 0);
    ticks(1);
    chk("R5 turn at bottom", 32'(cnt_o), 1);
    chk("R5 ovf at bottom", 32'(flags_o[0]), 1);
    ticks(32'h3F);
    chk("R5 pin high until up match", 32'(wave_o[0]), 1);
    ticks(1);
    chk("R5 clear on up match", 32'(wave_o[0]), 0);
  endtask

  task automatic t_pfc();
    do_reset();
    wr(5, 16'd10);
    wr(0, ctl(8, 0, 3, 0, 0, 0));
    wr(3, 16'd4);
    ticks(11);
    chk("R6 turn at capture top", 32'(cnt_o), 9);
    chk("R6 no ovf at top", 32'(flags_o[0]), 0);
    ticks(10);
    chk("R6 past bottom", 32'(cnt_o), 1);
    chk("R6 ovf at bottom", 32'(flags_o[0]), 1);
    chk("R6 code11 clear on down match", 32'(wave_o[1]), 0);
    ticks(3);
    chk("R6 before new compare", 32'(wave_o[1]), 0);
    ticks(1);
    chk("R6 set on up match after bottom update", 32'(wave_o[1]), 1);
  endtask

  task automatic t_conn();
    do_reset();
    wr(0, ctl(4, 0, 0, 0, 0, 0));
    wr(2, 16'd7);
    wr(0, ctl(15, 1, 1, 0, 0, 0));
    chk("R7 mode15 connection", 32'(wave_oe), 32'b001);
    ticks(8);
    chk("R7 mode15 top from compare A", 32'(cnt_o), 0);
    chk("R7 mode15 toggle A", 32'(wave_o), 32'b001);
    ticks(8);
    chk("R7 mode15 toggle back", 32'(wave_o[0]), 0);
    wr(0, ctl(14, 1, 0, 0, 0, 0));
    chk("R7 mode14 code01 off", 32'(wave_oe), 0);
    wr(0, ctl(11, 1, 1, 0, 0, 0));
    chk("R7 mode11 code01 A only", 32'(wave_oe), 32'b001);
    wr(0, ctl(10, 1, 0, 0, 0, 0));
    chk("R7 mode10 code01 off", 32'(wave_oe), 0);
    wr(0, ctl(0, 1, 1, 1, 0, 0));
    chk("R7 normal code01 all on", 32'(wave_oe), 32'b111);
  endtask

  task automatic t_capt();
    do_reset();
    wr(0, ctl(0, 0, 0, 0, 1, 0));
    wr(1, 16'h1234);
    capt_in = 1'b1;
    idle(6);
    chk("R8 rising capture flag", 32'(flags_o[4]), 1);
    chk("R8 rising capture value", 32'(capt_o), 32'h1234);
    wr(6, 16'h0010);
    wr(1, 16'h0055);
    capt_in = 1'b0;
    idle(6);
    chk("R8 falling ignored flag", 32'(flags_o[4]), 0);
    chk("R8 falling ignored value", 32'(capt_o), 32'h1234);
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    wr(1, 16'h0077);
    capt_in = 1'b1;
    idle(6);
    chk("R8 rising ignored when falling selected", 32'(flags_o[4]), 0);
    capt_in = 1'b0;
    idle(6);
    chk("R8 falling capture flag", 32'(flags_o[4]), 1);
    chk("R8 falling capture value", 32'(capt_o), 32'h0077);
    wr(0, ctl(12, 0, 0, 0, 1, 0));
    wr(6, 16'h001F);
    wr(5, 16'h0300);
    capt_in = 1'b1;
    idle(6);
    chk("R8 capture locked as top flag", 32'(flags_o[4]), 0);
    chk("R8 capture locked as top value", 32'(capt_o), 32'h0300);
    capt_in = 1'b0;
    idle(6);
  endtask

  task automatic t_filter();
    do_reset();
    wr(0, ctl(0, 0, 0, 0, 1, 1));
    capt_in = 1'b1;
    idle(3);
    capt_in = 1'b0;
    idle(8);
    chk("R9 short pulse filtered", 32'(flags_o[4]), 0);
    capt_in = 1'b1;
    idle(8);
    capt_in = 1'b0;
    idle(8);
    chk("R9 long pulse accepted", 32'(flags_o[4]), 1);
    wr(6, 16'h0010);
    wr(0, ctl(0, 0, 0, 0, 1, 0));
    idle(4);
    capt_in = 1'b1;
    idle(3);
    capt_in = 1'b0;
    idle(8);
    chk("R9 short pulse unfiltered", 32'(flags_o[4]), 1);
  endtask

  task automatic t_flags();
    do_reset();
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    wr(2, 16'h0100);
    wr(3, 16'h0100);
    wr(4, 16'h0100);
    wr(1, 16'hFFFF);
    ticks(1);
    chk("R10 ovf flag set", 32'(flags_o), 32'b00001);
    chk("R10 masked irq low", 32'(irq_o), 0);
    wr(7, 16'h0001);
    chk("R10 irq with mask", 32'(irq_o), 1);
    wr(6, 16'h0002);
    chk("R10 other clear keeps flag", 32'(flags_o[0]), 1);
    wr(6, 16'h0001);
    chk("R10 w1c clears flag", 32'(flags_o), 0);
    chk("R10 irq drops", 32'(irq_o), 0);
  endtask

  task automatic t_force();
    do_reset();
    wr(0, ctl(4, 3, 1, 0, 0, 0));
    wr(2, 16'h0100);
    wr(7, 16'h0100);
    chk("R11 force set A", 32'(wave_o[0]), 1);
    chk("R11 force no flag", 32'(flags_o[1]), 0);
    wr(7, 16'h0200);
    chk("R11 force toggle B", 32'(wave_o[1]), 1);
    wr(0, ctl(4, 2, 1, 0, 0, 0));
    wr(7, 16'h0100);
    chk("R11 force clear A", 32'(wave_o[0]), 0);
    wr(0, ctl(5, 3, 0, 0, 0, 0));
    wr(7, 16'h0100);
    chk("R11 force ignored in PWM", 32'(wave_o[0]), 0);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_ctc();
    t_fast();
    t_pc();
    t_pfc();
    t_conn();
    t_capt();
    t_filter();
    t_flags();
    t_force();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule